// File: doc/BRIEF.md
# Two-Level MESI Line State Controller

This block decides, for one cache line at a time, how an inclusive two-level cache reacts to a processor access. Each cycle it may receive one read or write. With the access come the hit flags and the current coherence states of the line in the first-level (L1) and second-level (L2) caches, plus four attribute inputs: the page writethrough bit, the bus writeback indication, the processor cacheability request and the bus cacheability acknowledge. In the same cycle it returns the next state for each level and a set of one-cycle action strobes. These strobes tell the surrounding datapath to fill L1, fill L2, write L1 or write L2, and the bus unit to perform a single read, a burst read or a single write.

The decision is purely combinational from the presented access. A short reset synchronizer gates every strobe, so that nothing is issued while reset is asserted or during the first cycles after it is released. A configuration parameter turns the L1 into an instruction cache. In that mode L1 keeps only a single valid state, and any write that touches L1 removes the L1 copy. Tags, data arrays, bus timing, snooping and replacement belong to other blocks.

Top module: `mesi_line_ctrl`

## Requirements
- R1: State codes are Invalid=00, Shared=01, Exclusive=10, Modified=11. The decision only takes effect in a cycle where `req_valid` is high, reset is not asserted, and at least 2 clock edges have passed since reset release. In any other cycle every action strobe and `err_incl` are low, and `l1_next`/`l2_next` equal `l1_state`/`l2_state`.
- R2: A read that hits L1 raises no action strobe and returns both states unchanged.
- R3: A read that misses L1 but hits L2 raises only `act_fill_l1`. L1 takes the allocation state and L2 keeps its state.
- R4: A read that misses both levels with `cpu_cacheable` and `bus_cacheable` both high raises `act_bus_burst`, `act_fill_l1` and `act_fill_l2`, and puts both levels in the allocation state.
- R5: A read that misses both levels with either cacheability input low raises only `act_bus_rd1`, and both levels stay Invalid.
- R6: The allocation state is Exclusive when `page_wt` is low and `bus_wb` is high, and Shared otherwise.
- R7: A write that hits an Exclusive or Modified L1 line raises only `act_wr_l1`. L1 becomes Modified and L2 is unchanged.
- R8: A write that hits a Shared L1 line raises `act_wr_l1`, `act_wr_l2` and `act_bus_wr1`, and both states are unchanged.
- R9: A write that misses L1 but hits L2 raises `act_wr_l2`. For a Shared L2 it also raises `act_bus_wr1` and L2 stays Shared. For an Exclusive or Modified L2 it raises no bus strobe and L2 becomes Modified. L1 stays Invalid.
- R10: A write that misses both levels never allocates: it raises only `act_bus_wr1`, and both levels stay Invalid.
- R11: A valid L1 state presented with an Invalid L2 state raises `err_incl`. In that case no action strobe is raised and both states are returned unchanged.
- R12: A level counts as hit only when its hit flag is high and its state is not Invalid.
- R13: With `L1_INSTR`=1, L1 fills take Shared, and an L1 Exclusive input is reported as Shared. A write that hits L1 sets L1 to Invalid, does not write L1, and treats L2 as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| l1_hit | input | 1 | L1 tag match |
| l2_hit | input | 1 | L2 tag match |
| l1_state | input | 2 | Current L1 line state |
| l2_state | input | 2 | Current L2 line state |
| page_wt | input | 1 | Page attribute: writethrough requested |
| bus_wb | input | 1 | Bus indicates writeback is allowed |
| cpu_cacheable | input | 1 | Processor requests a cacheable fill |
| bus_cacheable | input | 1 | Bus grants a cacheable fill |
| l1_next | output | 2 | Next L1 line state |
| l2_next | output | 2 | Next L2 line state |
| act_fill_l1 | output | 1 | Fill the L1 line |
| act_fill_l2 | output | 1 | Fill the L2 line |
| act_wr_l1 | output | 1 | Write data into L1 |
| act_wr_l2 | output | 1 | Write data into L2 |
| act_bus_rd1 | output | 1 | Single bus read |
| act_bus_burst | output | 1 | Burst bus read |
| act_bus_wr1 | output | 1 | Single bus write |
| err_incl | output | 1 | Inclusion violation on the presented states |

## Verification
The decision is tried with reads and writes at every hit/miss combination of the two levels, and with each lower-level state of Shared, Exclusive and Modified. This separates the writethrough path, the silent upgrade to Modified and the no-allocate bus write. Read misses are repeated under each mix of cacheability and writeback attributes, which separates the burst allocation from the single read and the Exclusive allocation from the Shared one. Hit flags paired with Invalid states, inclusion violations, gating during and just after reset, and a second instance in instruction-cache mode cover the remaining branches.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_e;

  typedef struct packed {
    logic fill_l1;
    logic fill_l2;
    logic wr_l1;
    logic wr_l2;
    logic bus_rd1;
    logic bus_burst;
    logic bus_wr1;
  } act_t;

  localparam act_t ACT_NONE = '0;

  function automatic logic st_valid(input mesi_e s);
    return s != ST_I;
  endfunction

endpackage

// File: rtl/mesi_rst_gate.sv
module mesi_rst_gate #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  always_comb begin
    sync_d[0] = 1'b1;
    for (int i = 1; i <= LAST; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run_o = sync_q[LAST];

endmodule

// File: rtl/mesi_attr_decode.sv
module mesi_attr_decode
  import mesi_pkg::*;
#(
  parameter bit L1_INSTR = 1'b0
) (
  input  logic  page_wt,
  input  logic  bus_wb,
  input  logic  cpu_cacheable,
  input  logic  bus_cacheable,
  output mesi_e l1_alloc,
  output mesi_e l2_alloc,
  output logic  burst_ok
);

  logic wb_line;

  assign wb_line  = !page_wt && bus_wb;
  assign l2_alloc = wb_line ? ST_E : ST_S;
  assign burst_ok = cpu_cacheable && bus_cacheable;

  generate
    if (L1_INSTR) begin : g_l1_instr
      assign l1_alloc = ST_S;
    end else begin : g_l1_data
      assign l1_alloc = wb_line ? ST_E : ST_S;
    end
  endgenerate

endmodule

// File: rtl/mesi_read_path.sv
module mesi_read_path
  import mesi_pkg::*;
(
  input  logic  l1_hit,
  input  logic  l2_hit,
  input  mesi_e l1_cur,
  input  mesi_e l2_cur,
  input  mesi_e l1_alloc,
  input  mesi_e l2_alloc,
  input  logic  burst_ok,
  output mesi_e l1_nx,
  output mesi_e l2_nx,
  output act_t  act
);

  always_comb begin
    l1_nx = l1_cur;
    l2_nx = l2_cur;
    act   = ACT_NONE;
    if (l1_hit) begin
      // served locally, nothing moves
    end else if (l2_hit) begin
      act.fill_l1 = 1'b1;
      l1_nx       = l1_alloc;
    end else if (burst_ok) begin
      act.bus_burst = 1'b1;
      act.fill_l1   = 1'b1;
      act.fill_l2   = 1'b1;
      l1_nx         = l1_alloc;
      l2_nx         = l2_alloc;
    end else begin
      act.bus_rd1 = 1'b1;
    end
  end

endmodule

// File: rtl/mesi_write_path.sv
module mesi_write_path
  import mesi_pkg::*;
#(
  parameter bit L1_INSTR = 1'b0
) (
  input  logic  l1_hit,
  input  logic  l2_hit,
  input  mesi_e l1_cur,
  input  mesi_e l2_cur,
  output mesi_e l1_nx,
  output mesi_e l2_nx,
  output act_t  act
);

  localparam bit L1_TAKES_WRITES = !L1_INSTR;

  logic l1_write_hit;

  assign l1_write_hit = l1_hit && L1_TAKES_WRITES;

  always_comb begin
    l1_nx = l1_cur;
    l2_nx = l2_cur;
    act   = ACT_NONE;
    if (l1_write_hit) begin
      act.wr_l1 = 1'b1;
      if (l1_cur == ST_S) begin
        act.wr_l2   = 1'b1;
        act.bus_wr1 = 1'b1;
      end else begin
        l1_nx = ST_M;
      end
    end else begin
      if (l1_hit) l1_nx = ST_I;
      if (l2_hit) begin
        act.wr_l2 = 1'b1;
        if (l2_cur == ST_S) act.bus_wr1 = 1'b1;
        else                l2_nx       = ST_M;
      end else begin
        act.bus_wr1 = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter bit L1_INSTR    = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_wr,
  input  logic       l1_hit,
  input  logic       l2_hit,
  input  logic [1:0] l1_state,
  input  logic [1:0] l2_state,
  input  logic       page_wt,
  input  logic       bus_wb,
  input  logic       cpu_cacheable,
  input  logic       bus_cacheable,
  output logic [1:0] l1_next,
  output logic [1:0] l2_next,
  output logic       act_fill_l1,
  output logic       act_fill_l2,
  output logic       act_wr_l1,
  output logic       act_wr_l2,
  output logic       act_bus_rd1,
  output logic       act_bus_burst,
  output logic       act_bus_wr1,
  output logic       err_incl
);

  logic  run;
  mesi_e l1_raw, l2_raw, l1_cur;
  logic  l1_hit_eff, l2_hit_eff;
  mesi_e l1_alloc, l2_alloc;
  logic  burst_ok;
  mesi_e rd_l1_nx, rd_l2_nx, wr_l1_nx, wr_l2_nx;
  act_t  rd_act, wr_act;
  logic  go, incl_bad;
  mesi_e l1_sel, l2_sel;
  act_t  act_sel;

  mesi_rst_gate #(.STAGES(SYNC_STAGES)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .run_o (run)
  );

  assign l1_raw = mesi_e'(l1_state);
  assign l2_raw = mesi_e'(l2_state);

  generate
    if (L1_INSTR) begin : g_ic_fold
      assign l1_cur = (l1_raw == ST_E) ? ST_S : l1_raw;
    end else begin : g_dc_pass
      assign l1_cur = l1_raw;
    end
  endgenerate

  assign l1_hit_eff = l1_hit && st_valid(l1_raw);
  assign l2_hit_eff = l2_hit && st_valid(l2_raw);

  mesi_attr_decode #(.L1_INSTR(L1_INSTR)) u_attr (
    .page_wt       (page_wt),
    .bus_wb        (bus_wb),
    .cpu_cacheable (cpu_cacheable),
    .bus_cacheable (bus_cacheable),
    .l1_alloc      (l1_alloc),
    .l2_alloc      (l2_alloc),
    .burst_ok      (burst_ok)
  );

  mesi_read_path u_rd (
    .l1_hit   (l1_hit_eff),
    .l2_hit   (l2_hit_eff),
    .l1_cur   (l1_cur),
    .l2_cur   (l2_raw),
    .l1_alloc (l1_alloc),
    .l2_alloc (l2_alloc),
    .burst_ok (burst_ok),
    .l1_nx    (rd_l1_nx),
    .l2_nx    (rd_l2_nx),
    .act      (rd_act)
  );

  mesi_write_path #(.L1_INSTR(L1_INSTR)) u_wr (
    .l1_hit (l1_hit_eff),
    .l2_hit (l2_hit_eff),
    .l1_cur (l1_cur),
    .l2_cur (l2_raw),
    .l1_nx  (wr_l1_nx),
    .l2_nx  (wr_l2_nx),
    .act    (wr_act)
  );

  assign go       = req_valid && run;
  assign incl_bad = st_valid(l1_raw) && !st_valid(l2_raw);

  always_comb begin
    l1_sel  = l1_raw;
    l2_sel  = l2_raw;
    act_sel = ACT_NONE;
    if (go && !incl_bad) begin
      if (req_wr) begin
        l1_sel  = wr_l1_nx;
        l2_sel  = wr_l2_nx;
        act_sel = wr_act;
      end else begin
        l1_sel  = rd_l1_nx;
        l2_sel  = rd_l2_nx;
        act_sel = rd_act;
      end
    end
  end

  assign l1_next       = l1_sel;
  assign l2_next       = l2_sel;
  assign act_fill_l1   = act_sel.fill_l1;
  assign act_fill_l2   = act_sel.fill_l2;
  assign act_wr_l1     = act_sel.wr_l1;
  assign act_wr_l2     = act_sel.wr_l2;
  assign act_bus_rd1   = act_sel.bus_rd1;
  assign act_bus_burst = act_sel.bus_burst;
  assign act_bus_wr1   = act_sel.bus_wr1;
  assign err_incl      = go && incl_bad;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (act_sel == ACT_NONE) && !err_incl && (l1_next == l1_state) && (l2_next == l2_state)); // R1

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_wr |-> !act_wr_l1 && !act_wr_l2 && !act_bus_wr1); // R2

  AST_BURST_FILLS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    act_bus_burst |-> act_fill_l1 && act_fill_l2 && !act_bus_rd1); // R4

  AST_ONE_BUS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_bus_rd1, act_bus_burst, act_bus_wr1})); // R10

  AST_WRITE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |-> !act_bus_rd1 && !act_bus_burst && !act_fill_l1 && !act_fill_l2); // R10

  AST_UPGRADE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && l2_state != 2'b11 && l2_next == 2'b11) |-> !act_bus_wr1); // R9

  AST_INCL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    err_incl |-> (act_sel == ACT_NONE) && (l1_next == l1_state) && (l2_next == l2_state)); // R11

endmodule

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_wr = 1'b0, l1_hit = 1'b0, l2_hit = 1'b0;
  logic [1:0] l1_state = 2'b00, l2_state = 2'b00;
  logic       page_wt = 1'b0, bus_wb = 1'b0, cpu_cacheable = 1'b0, bus_cacheable = 1'b0;

  logic [1:0] n1, n2, c1, c2;
  logic [6:0] act, cact;
  logic       err, cerr;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mesi_line_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .l1_hit(l1_hit), .l2_hit(l2_hit), .l1_state(l1_state), .l2_state(l2_state),
    .page_wt(page_wt), .bus_wb(bus_wb), .cpu_cacheable(cpu_cacheable),
    .bus_cacheable(bus_cacheable), .l1_next(n1), .l2_next(n2),
    .act_fill_l1(act[6]), .act_fill_l2(act[5]), .act_wr_l1(act[4]), .act_wr_l2(act[3]),
    .act_bus_rd1(act[2]), .act_bus_burst(act[1]), .act_bus_wr1(act[0]), .err_incl(err)
  );

  mesi_line_ctrl #(.L1_INSTR(1'b1)) uut_ic (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .l1_hit(l1_hit), .l2_hit(l2_hit), .l1_state(l1_state), .l2_state(l2_state),
    .page_wt(page_wt), .bus_wb(bus_wb), .cpu_cacheable(cpu_cacheable),
    .bus_cacheable(bus_cacheable), .l1_next(c1), .l2_next(c2),
    .act_fill_l1(cact[6]), .act_fill_l2(cact[5]), .act_wr_l1(cact[4]), .act_wr_l2(cact[3]),
    .act_bus_rd1(cact[2]), .act_bus_burst(cact[1]), .act_bus_wr1(cact[0]), .err_incl(cerr)
  );

  // act bits: fill_l1 fill_l2 wr_l1 wr_l2 bus_rd1 bus_burst bus_wr1
  typedef struct packed {
    logic       wr, h1, h2;
    logic [1:0] s1, s2;
    logic       pwt, wb, cc, bc;
    logic [1:0] e1, e2;
    logic [6:0] ea;
    logic       ee;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0,1'b1,1'b1,2'd2,2'd2,1'b0,1'b1,1'b1,1'b1,2'd2,2'd2,7'b0000000,1'b0,8'd2},  // R2
    '{1'b0,1'b1,1'b1,2'd3,2'd3,1'b1,1'b0,1'b1,1'b1,2'd3,2'd3,7'b0000000,1'b0,8'd2},  // R2
    '{1'b0,1'b0,1'b1,2'd0,2'd1,1'b0,1'b1,1'b0,1'b0,2'd2,2'd1,7'b1000000,1'b0,8'd3},  // R3 R6
    '{1'b0,1'b0,1'b1,2'd0,2'd3,1'b1,1'b1,1'b0,1'b0,2'd1,2'd3,7'b1000000,1'b0,8'd3},  // R3 R6
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,1'b1,1'b1,1'b1,2'd2,2'd2,7'b1100010,1'b0,8'd4},  // R4 R6
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b1,1'b1,2'd1,2'd1,7'b1100010,1'b0,8'd6},  // R6
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,1'b1,1'b0,1'b1,2'd0,2'd0,7'b0000100,1'b0,8'd5},  // R5
    '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,1'b1,1'b1,1'b0,2'd0,2'd0,7'b0000100,1'b0,8'd5},  // R5
    '{1'b1,1'b1,1'b1,2'd2,2'd2,1'b0,1'b1,1'b1,1'b1,2'd3,2'd2,7'b0010000,1'b0,8'd7},  // R7
    '{1'b1,1'b1,1'b1,2'd3,2'd3,1'b0,1'b1,1'b1,1'b1,2'd3,2'd3,7'b0010000,1'b0,8'd7},  // R7
    '{1'b1,1'b1,1'b1,2'd1,2'd1,1'b0,1'b1,1'b1,1'b1,2'd1,2'd1,7'b0011001,1'b0,8'd8},  // R8
    '{1'b1,1'b0,1'b1,2'd0,2'd1,1'b0,1'b1,1'b1,1'b1,2'd0,2'd1,7'b0001001,1'b0,8'd9},  // R9
    '{1'b1,1'b0,1'b1,2'd0,2'd2,1'b0,1'b1,1'b1,1'b1,2'd0,2'd3,7'b0001000,1'b0,8'd9},  // R9
    '{1'b1,1'b0,1'b1,2'd0,2'd3,1'b0,1'b1,1'b1,1'b1,2'd0,2'd3,7'b0001000,1'b0,8'd9},  // R9
    '{1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,1'b1,1'b1,1'b1,2'd0,2'd0,7'b0000001,1'b0,8'd10}, // R10
    '{1'b0,1'b1,1'b0,2'd2,2'd0,1'b0,1'b1,1'b1,1'b1,2'd2,2'd0,7'b0000000,1'b1,8'd11}, // R11
    '{1'b1,1'b1,1'b0,2'd1,2'd0,1'b0,1'b1,1'b1,1'b1,2'd1,2'd0,7'b0000000,1'b1,8'd11}, // R11
    '{1'b0,1'b1,1'b1,2'd0,2'd1,1'b0,1'b1,1'b1,1'b1,2'd2,2'd1,7'b1000000,1'b0,8'd12}, // R12
    '{1'b1,1'b0,1'b1,2'd0,2'd0,1'b0,1'b1,1'b1,1'b1,2'd0,2'd0,7'b0000001,1'b0,8'd12}  // R12
  };

  task automatic apply(input vec_t v);
    req_wr = v.wr; l1_hit = v.h1; l2_hit = v.h2;
    l1_state = v.s1; l2_state = v.s2;
    page_wt = v.pwt; bus_wb = v.wb; cpu_cacheable = v.cc; bus_cacheable = v.bc;
  endtask

  task automatic check(input string rq, input logic [1:0] a1, a2, input logic [6:0] aa,
                       input logic ae, input logic [1:0] x1, x2, input logic [6:0] xa,
                       input logic xe);
    tests++;
    if (a1 !== x1 || a2 !== x2 || aa !== xa || ae !== xe) begin
      fails++;
      $display("FAIL %s: got l1=%b l2=%b act=%b err=%b, expected l1=%b l2=%b act=%b err=%b",
               rq, a1, a2, aa, ae, x1, x2, xa, xe);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: in reset with a burst-worthy read presented, nothing is issued
    req_valid = 1'b1;
    apply(VECS[4]);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1 in reset", n1, n2, act, err, 2'd0, 2'd0, 7'b0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 first cycle after release", n1, n2, act, err, 2'd0, 2'd0, 7'b0, 1'b0);
    @(posedge clk); #1;
    check("R1 gate open", n1, n2, act, err, 2'd2, 2'd2, 7'b1100010, 1'b0);

    // R1: idle request returns states untouched
    @(negedge clk);
    req_valid = 1'b0;
    apply(VECS[8]);
    #1;
    check("R1 idle", n1, n2, act, err, 2'd2, 2'd2, 7'b0, 1'b0);
    req_valid = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      #1;
      check($sformatf("R%0d vec%0d", VECS[i].rq, i), n1, n2, act, err,
            VECS[i].e1, VECS[i].e2, VECS[i].ea, VECS[i].ee);
    end

    // R13: instruction-cache variant
    @(negedge clk);
    apply('{1'b0,1'b0,1'b1,2'd0,2'd2,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,7'b0,1'b0,8'd13});
    #1;
    check("R13 fill takes Shared", c1, c2, cact, cerr, 2'd1, 2'd2, 7'b1000000, 1'b0);
    @(negedge clk);
    apply('{1'b0,1'b1,1'b1,2'd2,2'd2,1'b0,1'b1,1'b1,1'b1,2'd0,2'd0,7'b0,1'b0,8'd13});
    #1;
    check("R13 E read as S", c1, c2, cact, cerr, 2'd1, 2'd2, 7'b0, 1'b0);
    @(negedge clk);
    apply('{1'b1,1'b1,1'b1,2'd1,2'd2,1'b0,1'b1,1'b1,1'b1,2'd0,2'd0,7'b0,1'b0,8'd13});
    #1;
    check("R13 write drops L1", c1, c2, cact, cerr, 2'd0, 2'd3, 7'b0001000, 1'b0);
    @(negedge clk);
    apply('{1'b1,1'b1,1'b1,2'd1,2'd1,1'b0,1'b1,1'b1,1'b1,2'd0,2'd0,7'b0,1'b0,8'd13});
    #1;
    check("R13 write drops L1, L2 shared", c1, c2, cact, cerr, 2'd0, 2'd1, 7'b0001001, 1'b0);

    // R11 in reset-asserted window again: reset gates error flag (R1)
    @(negedge clk);
    apply(VECS[15]);
    rst_n = 1'b0;
    #1;
    check("R1 error gated by reset", n1, n2, act, err, 2'd2, 2'd0, 7'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule